// File: doc/BRIEF.md
# Serial HDLC Frame Transmitter with Underrun Abort

This block turns bytes written by a host into a bit-serial HDLC line stream. The host places one byte at a time in a single-byte holding buffer. On each pulse of a bit-clock enable the block drives one bit onto its serial output. While no frame is running, it sends flag patterns. It starts a frame at the next flag boundary if two things hold: the host has cleared the frame-mode bit and a byte is waiting. Data goes out least significant bit first, and a zero is inserted after every run of five ones in the data.

After each byte moves from the buffer into the shifter, the host has eight bit times to supply the next byte. Two outcomes are possible when it is late:

- If end-of-frame-on-empty is disabled, the block declares an underrun. It raises both the underrun and abort/idle status bits and switches to sending ones in whole groups of eight. It keeps doing so until the host clears abort/idle. It then finishes the current group and returns to flags, and a new frame follows at once if the mode bit is 0.
- If end-of-frame-on-empty is enabled, an empty buffer at a byte boundary closes the frame with a flag instead. The block then sets the mode bit to 1 (idle on flags) and clears the underrun status.

Top module: `hdlc_abort_tx`

## Requirements
- R1: After reset the serial output is 1, the buffer is empty, underrun and abort/idle are 0, the mode bit is 0 and the first bit sent is bit 0 of a flag.
- R2: With no frame running, the block repeats the flag 0x7E, sending bit 0 first, one bit per bit-clock enable pulse.
- R3: At the last bit of a flag, if the mode bit is 0 and the buffer holds a byte, that byte is moved into the shifter and the buffer reads empty. Its bits follow, least significant bit first.
- R4: Within frame data, a 0 is sent after every five consecutive 1s. Flags and abort ones are sent without insertion.
- R5: A host write when the buffer is full changes nothing. The buffer-empty output is 1 exactly when the buffer can accept a write.
- R6: If auto-end is 0 and the buffer is still empty at the 8th bit-clock enable after a byte was taken into the shifter, underrun and abort/idle become 1 together. A byte written before that pulse avoids the underrun and is sent next.
- R7: After an underrun, the block sends 1s in groups of eight for as long as abort/idle is 1. A host clear of abort/idle takes effect only after the current group of eight is complete.
- R8: After the last abort group, the block sends flags. With the mode bit 0 and a byte buffered, a new frame starts after one flag. With the mode bit 1, flags continue even though a byte is buffered.
- R9: With auto-end at 1, underrun is never set. An empty buffer at the end of a data byte makes the block send one closing flag.
- R10: When the closing flag completes, the block sets the mode bit to 1 and clears underrun in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| wr_en | input | 1 | Host write strobe for the data buffer |
| wr_data | input | 8 | Byte to buffer |
| auto_eof | input | 1 | 1: close the frame on empty buffer and disable underrun detection |
| mode_wr | input | 1 | Host write strobe for the mode bit |
| mode_din | input | 1 | Mode value: 0 start frames, 1 idle on flags |
| abort_clr | input | 1 | Host pulse that clears abort/idle |
| txd | output | 1 | Serial data output |
| buf_empty | output | 1 | Buffer can take a byte |
| underrun | output | 1 | Underrun status |
| abort_idle | output | 1 | Abort/idle status |
| frame_mode | output | 1 | Current mode bit |

## Verification
Every result of this block appears at the clock edge that carries the bit-clock enable pulse: the new serial bit, the underrun and abort/idle bits at the eighth data bit, and the mode and underrun updates at the closing flag's last bit. The buffer-empty flag changes at the edge of the write strobe or the load. The bench therefore drives each stimulus for one cycle from the falling edge and reads the outputs at the next falling edge. It compares every emitted bit in order against a sequence built from flags, data bytes, inserted zeros and ones groups.

// File: rtl/hdlc_abort_tx.sv
module hdlc_abort_tx #(
  parameter int DL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       auto_eof,
  input  logic       mode_wr,
  input  logic       mode_din,
  input  logic       abort_clr,
  output logic       txd,
  output logic       buf_empty,
  output logic       underrun,
  output logic       abort_idle,
  output logic       frame_mode
);
  localparam int DLW = (DL > 2) ? $clog2(DL) : 1;
  localparam logic [DLW-1:0] DL_LAST = DLW'(DL - 1);
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_CLOSE, S_ABORT} st_t;
  st_t st;
  logic [7:0] buf_q, sh;
  logic [2:0] cnt, ones;
  logic [DLW-1:0] dl;

  wire last  = (cnt == 3'd7);
  wire stuff = (ones == 3'd5);
  wire late  = (st == S_DATA) && bit_en && (dl == DL_LAST) && buf_empty && !auto_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; buf_q <= '0; sh <= '0; cnt <= '0; ones <= '0; dl <= '0;
      txd <= 1'b1; buf_empty <= 1'b1; underrun <= 1'b0; abort_idle <= 1'b0;
      frame_mode <= 1'b0;
    end else begin
      if (wr_en && buf_empty) begin
        buf_q <= wr_data;
        buf_empty <= 1'b0;
      end
      if (mode_wr) frame_mode <= mode_din;
      if (abort_clr) abort_idle <= 1'b0;
      if (bit_en) begin
        case (st)
          S_IDLE: begin
            txd <= FLAG[cnt];
            cnt <= cnt + 3'd1;
            if (last && !frame_mode && !buf_empty) begin
              st <= S_DATA; sh <= buf_q; buf_empty <= 1'b1; dl <= '0; ones <= '0;
            end
          end
          S_DATA: begin
            if (dl != DL_LAST) dl <= dl + 1'b1;
            if (stuff) begin
              txd <= 1'b0;
              ones <= '0;
            end else begin
              txd <= sh[0];
              sh <= sh >> 1;
              ones <= sh[0] ? ones + 3'd1 : 3'd0;
              cnt <= cnt + 3'd1;
              if (last) begin
                if (!buf_empty) begin
                  sh <= buf_q; buf_empty <= 1'b1; dl <= '0;
                end else if (auto_eof) begin
                  st <= S_CLOSE;
                end
              end
            end
            if (late) begin
              st <= S_ABORT; cnt <= '0; underrun <= 1'b1; abort_idle <= 1'b1;
            end
          end
          S_CLOSE: begin
            if (cnt == 3'd0 && stuff) begin
              txd <= 1'b0;
              ones <= '0;
            end else begin
              txd <= FLAG[cnt];
              ones <= '0;
              cnt <= cnt + 3'd1;
              if (last) begin
                st <= S_IDLE; frame_mode <= 1'b1; underrun <= 1'b0;
              end
            end
          end
          default: begin
            txd <= 1'b1;
            cnt <= cnt + 3'd1;
            if (last && !abort_idle) st <= S_IDLE;
          end
        endcase
      end
    end
  end

  p_abort_with_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> abort_idle);
  p_ones_in_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABORT && bit_en) |=> txd);
  p_group_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABORT && !(bit_en && last)) |=> st == S_ABORT);
  p_no_underrun_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eof && !underrun && !late) |=> !underrun);
  p_run_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> ones <= 3'd5);
  p_full_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_empty) |=> $stable(buf_q));
  p_close_updates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSE && bit_en && last && !(cnt == 3'd0 && stuff)) |=> (frame_mode && !underrun));
endmodule

// File: tb/hdlc_abort_tx_bench.sv
module hdlc_abort_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic auto_eof = 1'b0, mode_wr = 1'b0, mode_din = 1'b0, abort_clr = 1'b0;
  logic txd, buf_empty, underrun, abort_idle, frame_mode;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hdlc_abort_tx u_hdlc_abort_tx (.clk, .rst_n, .bit_en, .wr_en, .wr_data, .auto_eof,
    .mode_wr, .mode_din, .abort_clr, .txd, .buf_empty, .underrun, .abort_idle, .frame_mode);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic expect_bits(input logic [31:0] v, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      check(txd === v[i], req, txd, v[i]);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk) begin mode_wr = 1'b1; mode_din = m; end
    @(negedge clk) mode_wr = 1'b0;
  endtask

  task automatic clear_abort();
    @(negedge clk) abort_clr = 1'b1;
    @(negedge clk) abort_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(buf_empty === 1'b1, "R1 buf_empty", buf_empty, 1);
    check(underrun === 1'b0 && abort_idle === 1'b0, "R1 status", {underrun, abort_idle}, 0);
    check(frame_mode === 1'b0, "R1 mode", frame_mode, 0);
  endtask

  task automatic t_idle_flags();
    expect_bits(32'h7E7E, 16, "R2 idle flags");
  endtask

  task automatic t_stuff_close();
    @(negedge clk) auto_eof = 1'b1;
    host_write(8'hFF);
    check(buf_empty === 1'b0, "R5 buffer full", buf_empty, 0);
    expect_bits(32'h7E, 8, "R2 opening flag");
    check(buf_empty === 1'b1, "R3 buffer taken", buf_empty, 1);
    expect_bits(32'h1DF, 9, "R4 zero insertion");
    expect_bits(32'h7E, 8, "R9 closing flag");
    check(underrun === 1'b0, "R9 no underrun", underrun, 0);
    check(frame_mode === 1'b1, "R10 mode set", frame_mode, 1);
  endtask

  task automatic t_on_time();
    @(negedge clk) auto_eof = 1'b0;
    set_mode(1'b0);
    host_write(8'h12);
    expect_bits(32'h7E, 8, "R3 flag before frame");
    expect_bits(32'h2, 4, "R3 low nibble");
    host_write(8'h34);
    expect_bits(32'h1, 4, "R3 high nibble");
    check(underrun === 1'b0, "R6 on-time byte", underrun, 0);
    @(negedge clk) auto_eof = 1'b1;
    expect_bits(32'h34, 8, "R6 next byte sent");
    expect_bits(32'h7E, 8, "R9 closing flag");
    check(underrun === 1'b0 && frame_mode === 1'b1, "R10 after close", {underrun, frame_mode}, 1);
  endtask

  task automatic t_underrun_newframe();
    @(negedge clk) auto_eof = 1'b0;
    set_mode(1'b0);
    host_write(8'h55);
    expect_bits(32'h7E, 8, "R3 flag");
    expect_bits(32'h55, 8, "R3 data lsb first");
    check(underrun === 1'b1 && abort_idle === 1'b1, "R6 underrun raised", {underrun, abort_idle}, 3);
    expect_bits(32'hFF, 8, "R7 first ones group");
    check(abort_idle === 1'b1, "R7 abort held", abort_idle, 1);
    expect_bits(32'h7, 3, "R7 second group start");
    clear_abort();
    host_write(8'h0F);
    @(negedge clk) auto_eof = 1'b1;
    expect_bits(32'h1F, 5, "R7 group completes");
    expect_bits(32'h7E, 8, "R8 flag after abort");
    expect_bits(32'h0F, 8, "R8 new frame");
    check(underrun === 1'b1, "R10 underrun held until close", underrun, 1);
    expect_bits(32'h7E, 8, "R9 closing flag");
    check(underrun === 1'b0 && frame_mode === 1'b1, "R10 cleared at close", {underrun, frame_mode}, 1);
  endtask

  task automatic t_underrun_flags();
    @(negedge clk) auto_eof = 1'b0;
    set_mode(1'b0);
    host_write(8'h00);
    expect_bits(32'h7E, 8, "R3 flag");
    expect_bits(32'h00, 8, "R3 zero byte");
    check(underrun === 1'b1 && abort_idle === 1'b1, "R6 underrun raised", {underrun, abort_idle}, 3);
    set_mode(1'b1);
    host_write(8'hA5);
    host_write(8'h3C);
    check(buf_empty === 1'b0, "R5 still full", buf_empty, 0);
    clear_abort();
    expect_bits(32'hFF, 8, "R7 group completes");
    expect_bits(32'h7E7E, 16, "R8 flags in mode 1");
    check(buf_empty === 1'b0, "R8 byte kept", buf_empty, 0);
    @(negedge clk) auto_eof = 1'b1;
    set_mode(1'b0);
    expect_bits(32'h7E, 8, "R8 flag");
    expect_bits(32'hA5, 8, "R5 first byte kept");
    expect_bits(32'h7E, 8, "R9 closing flag");
    check(frame_mode === 1'b1 && underrun === 1'b0, "R10 after close", {frame_mode, underrun}, 2);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_flags();
    t_stuff_close();
    t_on_time();
    t_underrun_newframe();
    t_underrun_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule